// File: doc/BRIEF.md
# Three-wire serial EEPROM word reader

This block fetches one 16-bit word from a three-wire serial EEPROM. A host places a 6-bit word address on `rd_addr` and pulses `rd_start`. The block then takes over the memory pins. It drives chip select, the serial clock and the serial data line into the memory. It sends an 11-bit read frame and then clocks 16 data bits back in from the memory's output pin. When the read is finished, it presents the word on `word_out`, with its two bytes exchanged, and raises `done` for one cycle.

Each half of the serial clock lasts one phase. The length of a phase is set by `phase_len` in system clock cycles. The value is captured when a read is accepted, and any value below 3 is raised to 3. The returning data passes through a two-flop synchroniser, and this minimum phase length covers the synchroniser's latency. `busy` reports an ongoing read. A start request made while a read is in progress is ignored.

Top module: `eerd_word_reader`

## Requirements
- R1: While `rst_n` is low and after its release, `ee_cs`, `ee_sck`, `ee_sdo`, `busy` and `done` are 0 and `word_out` is 0.
- R2: The frame leaves on `ee_sdo` most significant bit first as 11 bits: 0, 0, 1, 1, 0, then address bits 5 down to 0. Each bit is set up while `ee_sck` is low and held through the high phase and the low phase that follows.
- R3: Every high phase of `ee_sck` lasts exactly L system cycles, where L = max(`phase_len`, 3), using the value captured at the accepted start. A change to `phase_len` during a read has no effect on that read.
- R4: `ee_cs` stays low for one phase after the start. It then stays high across exactly 27 rising edges of `ee_sck` (11 command and 16 data) and falls after the last data bit. `ee_sck` is never high while `ee_cs` is low.
- R5: During the 16 data clocks `ee_sdo` is 0. The data bit is taken from `ee_sdi` at the end of each high phase and shifted in from the LSB, so the first bit received ends up most significant in the assembled value.
- R6: `word_out` is the assembled value with its bytes exchanged: the first byte received is placed in bits 7:0.
- R7: `done` rises exactly 66·L clock edges after the edge that accepted `rd_start`.
- R8: `busy` is high from the accepting edge through the `done` cycle and low the cycle after. `done` lasts one cycle.
- R9: A `rd_start` pulse while `busy` is high changes neither the address read, nor the phase length, nor the timing.
- R10: `word_out` changes only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_start | input | 1 | Start request, accepted when idle |
| rd_addr | input | 6 | Word address to read |
| phase_len | input | 8 | System cycles per serial clock phase (minimum 3 applied) |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sck | output | 1 | Serial clock to the memory |
| ee_sdo | output | 1 | Serial data into the memory |
| ee_sdi | input | 1 | Serial data out of the memory (asynchronous) |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion strobe |
| word_out | output | 16 | Byte-swapped word of the last completed read |

## Verification
A read is accepted on one edge. `done` is due exactly 66·L edges later: one preamble phase, three phases per command bit and two per data bit. The bench counts edges from the accepting edge and compares that count to 66·L. It samples 1 ns after each edge. In the cycle following `done` it expects `done` and `busy` to be low. The memory model observes the pins on falling edges. It presents each data bit just after it sees a rising `ee_sck`, which gives the synchroniser two cycles to settle before the end-of-phase sample. Once chip select falls, the model's captured frame, its count of rising edges and the lengths of the high phases are compared against the values computed for the address and L.

// File: rtl/eerd_pkg.sv
// Shared types and constants for the serial EEPROM word reader.
// Assumes a read frame made of two leading zeros, a start bit and a two-bit opcode.
package eerd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // pins quiet, waiting for a start
        ST_PRE,    // chip select held low for one phase
        ST_CSET,   // command bit set up, clock low
        ST_CHI,    // command bit, clock high
        ST_CHOLD,  // command bit held, clock low
        ST_RHI,    // data bit, clock high, sample at phase end
        ST_RLO,    // data bit, clock low
        ST_DONE    // one-cycle completion
    } eerd_state_t;

    localparam int unsigned MIN_PHASE = 3;        // covers the two-flop input synchroniser
    localparam logic [4:0]  READ_HEAD = 5'b00110; // two zeros, start bit, opcode 10
endpackage

// File: rtl/eerd_sync2.sv
// Two-flop synchroniser for an asynchronous input.
// Assumes the consumer tolerates two cycles of latency.
module eerd_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Pass the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/eerd_phase_timer.sv
// Counts the system cycles of each serial-clock phase.
// It captures the phase length on load and clamps it to MIN_PHASE.
// While run is high it gives one tick in the last cycle of every phase.
module eerd_phase_timer
    import eerd_pkg::*;
#(
    parameter int unsigned PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PHASE_W-1:0] len,
    input  logic               run,
    output logic               tick
);
    localparam logic [PHASE_W-1:0] MIN_LEN = PHASE_W'(MIN_PHASE);

    logic [PHASE_W-1:0] len_eff;
    logic [PHASE_W-1:0] len_q;
    logic [PHASE_W-1:0] cnt;

    // Raise a short requested length to the minimum.
    always_comb len_eff = (len < MIN_LEN) ? MIN_LEN : len;

    // Capture the length on load, then count down each phase and reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= MIN_LEN;
            cnt   <= '0;
        end else if (load) begin
            len_q <= len_eff;
            cnt   <= len_eff - 1'b1;
        end else if (run) begin
            cnt <= (cnt == '0) ? len_q - 1'b1 : cnt - 1'b1;
        end
    end

    // A phase ends when the count reaches zero.
    always_comb tick = run && (cnt == '0);
endmodule

// File: rtl/eerd_sequencer.sv
// Drives the serial pins through the read frame and collects the data bits.
// Assumes that tick marks the last cycle of each phase and that sdi_s is already synchronised.
module eerd_sequencer
    import eerd_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tick,
    input  logic              sdi_s,
    output logic              load,
    output logic              run,
    output logic              cs,
    output logic              sck,
    output logic              sdo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] word
);
    localparam int unsigned FRAME_W = ADDR_W + 5;
    localparam int unsigned NBYTES  = DATA_W / 8;
    localparam int unsigned MAXBITS = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
    localparam int unsigned CNT_W   = $clog2(MAXBITS);

    eerd_state_t        state;
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   bit_cnt;
    logic [DATA_W-1:0]  acc;
    logic [DATA_W-1:0]  acc_swapped;

    // Reverse the byte order of the assembled value.
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign acc_swapped[b*8 +: 8] = acc[(NBYTES-1-b)*8 +: 8];
    end

    // Step through the preamble, the command bits and the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            frame_q <= '0;
            bit_cnt <= '0;
            acc     <= '0;
            word    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    frame_q <= {READ_HEAD, addr};
                    bit_cnt <= '0;
                    state   <= ST_PRE;
                end
                ST_PRE:  if (tick) state <= ST_CSET;
                ST_CSET: if (tick) state <= ST_CHI;
                ST_CHI:  if (tick) state <= ST_CHOLD;
                ST_CHOLD: if (tick) begin
                    if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
                        bit_cnt <= '0;
                        state   <= ST_RHI;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                        state   <= ST_CSET;
                    end
                end
                ST_RHI: if (tick) begin
                    acc   <= {acc[DATA_W-2:0], sdi_s};
                    state <= ST_RLO;
                end
                ST_RLO: if (tick) begin
                    if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                        word  <= acc_swapped;
                        state <= ST_DONE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= ST_RHI;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the pin levels and the handshake signals from the state.
    always_comb begin
        load = (state == ST_IDLE) && start;
        run  = (state != ST_IDLE) && (state != ST_DONE);
        cs   = (state == ST_CSET) || (state == ST_CHI) || (state == ST_CHOLD)
            || (state == ST_RHI)  || (state == ST_RLO);
        sck  = (state == ST_CHI)  || (state == ST_RHI);
        sdo  = ((state == ST_CSET) || (state == ST_CHI) || (state == ST_CHOLD))
            && frame_q[FRAME_W-1];
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end
endmodule

// File: rtl/eerd_word_reader.sv
// Top level: reads one word from a three-wire serial EEPROM.
// Assumes ee_sdi is asynchronous and that phase_len fits PHASE_W bits.
module eerd_word_reader #(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_start,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [PHASE_W-1:0] phase_len,
    output logic               ee_cs,
    output logic               ee_sck,
    output logic               ee_sdo,
    input  logic               ee_sdi,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  word_out
);
    logic sdi_s;
    logic tick;
    logic load;
    logic run;

    eerd_sync2 #(.W(1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ee_sdi),
        .q_sync  (sdi_s)
    );

    eerd_phase_timer #(.PHASE_W(PHASE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .len   (phase_len),
        .run   (run),
        .tick  (tick)
    );

    eerd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rd_start),
        .addr  (rd_addr),
        .tick  (tick),
        .sdi_s (sdi_s),
        .load  (load),
        .run   (run),
        .cs    (ee_cs),
        .sck   (ee_sck),
        .sdo   (ee_sdo),
        .busy  (busy),
        .done  (done),
        .word  (word_out)
    );
endmodule

// File: rtl/eerd_word_reader_chk.sv
// Checker for the port-level protocol of eerd_word_reader, attached by bind.
module eerd_word_reader_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_start,
    input logic              ee_cs,
    input logic              ee_sck,
    input logic              ee_sdo,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] word_out
);
    a_r1_idle_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_sck && !ee_sdo));

    a_r3_sck_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sck) |=> ee_sck);

    a_r4_sck_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sck |-> ee_cs);

    a_r5_sdo_low_when_sck_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ee_sdo && !ee_cs));

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_busy_covers_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r9_start_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && rd_start) |=> busy);

    a_r10_word_changes_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> done);
endmodule

bind eerd_word_reader eerd_word_reader_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .ee_cs    (ee_cs),
    .ee_sck   (ee_sck),
    .ee_sdo   (ee_sdo),
    .busy     (busy),
    .done     (done),
    .word_out (word_out)
);

// File: tb/eerd_word_reader_bench.sv
module eerd_word_reader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_start = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [7:0]  phase_len = 8'd3;
    logic        ee_cs, ee_sck, ee_sdo, busy, done;
    logic        ee_sdi = 1'b0;
    logic [15:0] word_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    eerd_word_reader u_eerd_word_reader (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
        .phase_len(phase_len), .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_sdo(ee_sdo),
        .ee_sdi(ee_sdi), .busy(busy), .done(done), .word_out(word_out)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [5:0] a);
        return 16'((int'(a) * 1733) ^ 16'hC3A5);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: observes the pins on falling clock edges.
    logic        prev_sck = 0, prev_cs = 0;
    int          rises = 0, hi_run = 0, hi_min = 0, hi_max = 0;
    logic [10:0] cmd_cap = '0;
    bit          mosi_bad = 0;
    logic [10:0] last_cmd = '0;
    int          last_rises = 0, last_hi_min = 0, last_hi_max = 0;
    bit          last_mosi_bad = 0;
    logic [15:0] model_word = '0;

    always @(negedge clk) begin
        if (ee_cs && !prev_cs) begin
            rises = 0; cmd_cap = '0; mosi_bad = 0;
            hi_run = 0; hi_min = 1000000; hi_max = 0;
            model_word = mem_word(rd_addr);
        end
        if (ee_cs) begin
            if (ee_sck) hi_run++;
            else if (prev_sck) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                hi_run = 0;
            end
            if (ee_sck && !prev_sck) begin
                rises++;
                if (rises <= 11) cmd_cap = {cmd_cap[9:0], ee_sdo};
                else begin
                    if (ee_sdo) mosi_bad = 1;
                    if (rises <= 27) ee_sdi = model_word[15 - (rises - 12)];
                end
            end
        end
        if (!ee_cs && prev_cs) begin
            last_cmd = cmd_cap; last_rises = rises;
            last_hi_min = hi_min; last_hi_max = hi_max;
            last_mosi_bad = mosi_bad;
            ee_sdi = 1'b0;
        end
        prev_sck = ee_sck;
        prev_cs  = ee_cs;
    end

    logic [15:0] prev_word = '0;

    task automatic run_txn(input logic [5:0] a, input logic [7:0] plen, input bit poke);
        int L;
        int n;
        bit busy_bad;
        bit stable_bad;
        logic [15:0] exp_raw;
        logic [15:0] exp_word;
        L = (plen < 3) ? 3 : int'(plen);
        exp_raw  = mem_word(a);
        exp_word = {exp_raw[7:0], exp_raw[15:8]};
        n = 0; busy_bad = 0; stable_bad = 0;
        @(negedge clk);
        rd_addr = a; phase_len = plen; rd_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_start = 1'b0;
        check(busy === 1'b1, "R8", "busy after accept", int'(busy), 1);
        while (1) begin
            @(posedge clk);
            #1;
            n++;
            if (done === 1'b1 || n > 20000) break;
            if (busy !== 1'b1) busy_bad = 1;
            if (word_out !== prev_word) stable_bad = 1;
            if (poke && n == 20) begin
                // R9: request a different read and phase length mid-transaction
                rd_start = 1'b1; rd_addr = ~a; phase_len = 8'd9;
            end
            if (poke && n == 21) begin
                rd_start = 1'b0; rd_addr = a;
            end
        end
        check(n == 66 * L, "R7", "done latency", n, 66 * L);
        check(!busy_bad, "R8", "busy held during read", int'(busy_bad), 0);
        check(!stable_bad, "R10", "word stable before done", int'(stable_bad), 0);
        check(word_out === exp_word, "R6", "byte-swapped word", int'(word_out), int'(exp_word));
        @(posedge clk);
        #1;
        check(done === 1'b0 && busy === 1'b0, "R8", "done one cycle then idle",
              int'({done, busy}), 0);
        check(word_out === exp_word, "R10", "word held after done", int'(word_out), int'(exp_word));
        check(last_cmd === {5'b00110, a}, "R2", "command frame", int'(last_cmd),
              int'({5'b00110, a}));
        check(last_rises == 27, "R4", "clock rises per read", last_rises, 27);
        check(!last_mosi_bad, "R5", "sdo low during data", int'(last_mosi_bad), 0);
        check(last_hi_min == L && last_hi_max == L, "R3", "high phase length",
              last_hi_max, L);
        if (poke)
            check(n == 66 * L && word_out === exp_word, "R9", "start while busy ignored",
                  n, 66 * L);
        prev_word = exp_word;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check({ee_cs, ee_sck, ee_sdo, busy, done} === 5'b0, "R1", "pins during reset",
              int'({ee_cs, ee_sck, ee_sdo, busy, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check({ee_cs, ee_sck, ee_sdo, busy, done} === 5'b0 && word_out === 16'h0, "R1",
              "state after reset", int'({ee_cs, ee_sck, ee_sdo, busy, done}), 0);
        // Full sweep of addresses at the minimum phase length
        for (int a = 0; a < 64; a++) run_txn(6'(a), 8'd3, (a % 16) == 5);
        // Other phase lengths, including ones clamped up to 3 (R3)
        run_txn(6'd0,  8'd0, 1'b0);
        run_txn(6'd63, 8'd1, 1'b0);
        run_txn(6'd42, 8'd2, 1'b1);
        run_txn(6'd21, 8'd5, 1'b1);
        run_txn(6'd7,  8'd8, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: ends a run that hangs.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule